// File: doc/BRIEF.md
# Parity and System Error Control

This block holds a small bank of single-bit system controls that software can only write, and it generates and checks odd parity on the byte lanes of a 16-bit memory data path. A control write selects one control with a 3-bit select field and takes the new value from data bit 15 alone. All accesses are 16-bit transfers to even addresses, so byte lanes are chosen by the byte strobes only.

On memory writes the block produces one parity bit for each byte lane. A control can force that parity wrong so that the error path can be tested. On memory reads it compares the stored parity of each enabled lane with the data. A mismatch sets a sticky error flag, which drives a parity interrupt request and, when system errors are unmasked, a bus-error/NMI request. The block also drives a ROM low-address overlay enable, two modem line disconnect levels and a dialer line select.

Top module: `sysctl_parity_unit`

## Requirements
- R1: When `ctl_we` is high at a clock edge, control number `ctl_sel` takes the value of `ctl_wdata[15]` from the next cycle on. Data bits 14..0 have no effect, and every other control keeps its value.
- R2: Synchronous active-high reset clears all controls and the error flag. After reset `rom_low_en`=1, both line disconnects are 0, `dialer_line2`=0, `par_irq`=0 and `sys_err_req`=0.
- R3: Lane i is data bits [8i+7:8i]. With control 2 at 0, `par_out[i]` is 1 exactly when that byte holds an even number of ones (odd parity over byte plus parity bit). The output is combinational. `par_we` equals `mem_be` while `mem_we` is 1 and is 0 otherwise.
- R4: With control 2 (force bad parity) at 1, both `par_out` bits are the inverse of their R3 values.
- R5: A read (`mem_rd`=1) finds an error on lane i when `mem_be[i]`=1 and `mem_rpar[i]` differs from the R3 parity of `mem_rdata` lane i. Lanes with a clear strobe are never checked. An error sets `err_flag` at the next edge only when control 1 (parity reporting enable) is 1.
- R6: `err_flag` stays set until a cycle with `err_clr`=1 clears it. If a new error is detected in the same cycle as `err_clr`, the flag stays set.
- R7: `par_irq` = `err_flag` AND control 1. `sys_err_req` = `err_flag` AND control 1 AND control 0 (system error enable).
- R8: `status_word` bit 10 shows control 1. All other status bits are 0.
- R9: `rom_low_en` is the inverse of control 3. `line1_disc` follows control 4, `line2_disc` follows control 5, and `dialer_line2` follows control 6.
- R10: A write to control 7 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_sel | input | 3 | Control number to write |
| ctl_wdata | input | 16 | Write data; only bit 15 is used |
| mem_we | input | 1 | Memory write cycle |
| mem_rd | input | 1 | Memory read cycle |
| mem_be | input | 2 | Byte lane strobes |
| mem_wdata | input | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_rpar | input | 2 | Stored parity returned with read data |
| err_clr | input | 1 | Clears the sticky error flag |
| par_out | output | 2 | Generated parity per lane |
| par_we | output | 2 | Parity write enable per lane |
| err_flag | output | 1 | Sticky parity error flag |
| par_irq | output | 1 | Parity interrupt request |
| sys_err_req | output | 1 | Bus-error/NMI request |
| status_word | output | 16 | Status word with the parity enable state in bit 10 |
| rom_low_en | output | 1 | ROM overlaid on low addresses |
| line1_disc | output | 1 | Modem line 1 disconnected |
| line2_disc | output | 1 | Modem line 2 disconnected |
| dialer_line2 | output | 1 | Dialer routed to line 2 |

## Verification
A corrupted control register shows at the ports one cycle after the write that loads it. It appears either directly on the line, ROM and status outputs, or as inverted parity and a masked or unmasked request. A wrong error flag shows on `err_flag` and on the two requests at the edge after the read or clear that should have changed it. Parity logic is combinational, so a wrong lane value shows in the same cycle. For that reason every byte value is swept on both lanes, and every mix of strobes, corrupted lanes and enables is applied to the checker.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int BYTE_W       = 8;
    localparam int VAL_BIT      = 15;
    localparam int STAT_PE_BIT  = 10;
    localparam int USED_CTL     = 7;

    // Decoded control bits; field order matches control numbers 6 down to 0.
    typedef struct packed {
        logic dial_line2;
        logic line2_off;
        logic line1_off;
        logic rom_hide;
        logic force_bad;
        logic rep_en;
        logic syserr_en;
    } ctrl_t;

    // Parity bit that makes byte plus parity carry an odd count of ones.
    function automatic logic odd_fill(input logic [BYTE_W-1:0] b);
        return ~(^b);
    endfunction

endpackage

// File: rtl/sysctl_ctrl_bank.sv
module sysctl_ctrl_bank
    import sysctl_pkg::*;
#(
    parameter int NCTL  = 8,
    localparam int SEL_W = $clog2(NCTL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic             val,
    output logic [NCTL-1:0]  ctrl_q
);

    generate
        for (genvar k = 0; k < NCTL; k++) begin : g_bit
            always_ff @(posedge clk) begin
                if (rst)
                    ctrl_q[k] <= 1'b0;
                else if (we && sel == SEL_W'(k))
                    ctrl_q[k] <= val;
            end
        end
    endgenerate

    assert_reset_clear_R2: assert property (@(posedge clk)
        rst |=> ctrl_q == '0);

    assert_write_loads_R1: assert property (@(posedge clk) disable iff (rst)
        we |=> ctrl_q[$past(sel)] == $past(val));

    assert_idle_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(ctrl_q));

    assert_single_change_R1: assert property (@(posedge clk) disable iff (rst)
        we |=> $countones(ctrl_q ^ $past(ctrl_q)) <= 1);

endmodule

// File: rtl/sysctl_par_gen.sv
module sysctl_par_gen
    import sysctl_pkg::*;
#(
    parameter int LANES = 2,
    localparam int DW   = LANES * BYTE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [LANES-1:0] be,
    input  logic [DW-1:0]    wdata,
    input  logic             force_bad,
    output logic [LANES-1:0] par,
    output logic [LANES-1:0] par_we
);

    assign par_we = we ? be : '0;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign par[i] = odd_fill(wdata[i*BYTE_W +: BYTE_W]) ^ force_bad;

            assert_odd_total_R3: assert property (@(posedge clk) disable iff (rst)
                (we && be[i] && !force_bad) |-> ^{wdata[i*BYTE_W +: BYTE_W], par[i]});

            assert_bad_total_R4: assert property (@(posedge clk) disable iff (rst)
                (we && be[i] && force_bad) |-> !(^{wdata[i*BYTE_W +: BYTE_W], par[i]}));
        end
    endgenerate

endmodule

// File: rtl/sysctl_par_check.sv
module sysctl_par_check
    import sysctl_pkg::*;
#(
    parameter int LANES = 2,
    localparam int DW   = LANES * BYTE_W
) (
    input  logic             rd,
    input  logic [LANES-1:0] be,
    input  logic [DW-1:0]    rdata,
    input  logic [LANES-1:0] rpar,
    output logic [LANES-1:0] lane_bad
);

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            logic expect_par;
            assign expect_par  = odd_fill(rdata[i*BYTE_W +: BYTE_W]);
            assign lane_bad[i] = rd && be[i] && (rpar[i] != expect_par);
        end
    endgenerate

endmodule

// File: rtl/sysctl_err_track.sv
module sysctl_err_track (
    input  logic clk,
    input  logic rst,
    input  logic hit,
    input  logic rep_en,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (hit && rep_en)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    assert_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);

    assert_set_needs_enable_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past(rep_en) && $past(hit));

    assert_clear_works_R6: assert property (@(posedge clk) disable iff (rst)
        (clr && !(hit && rep_en)) |=> !flag);

endmodule

// File: rtl/sysctl_parity_unit.sv
module sysctl_parity_unit
    import sysctl_pkg::*;
#(
    parameter int LANES = 2,
    parameter int NCTL  = 8,
    localparam int DW    = LANES * BYTE_W,
    localparam int SEL_W = $clog2(NCTL)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_we,
    input  logic [SEL_W-1:0] ctl_sel,
    input  logic [DW-1:0]    ctl_wdata,
    input  logic             mem_we,
    input  logic             mem_rd,
    input  logic [LANES-1:0] mem_be,
    input  logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    input  logic [LANES-1:0] mem_rpar,
    input  logic             err_clr,
    output logic [LANES-1:0] par_out,
    output logic [LANES-1:0] par_we,
    output logic             err_flag,
    output logic             par_irq,
    output logic             sys_err_req,
    output logic [DW-1:0]    status_word,
    output logic             rom_low_en,
    output logic             line1_disc,
    output logic             line2_disc,
    output logic             dialer_line2
);

    logic [NCTL-1:0]  ctrl_q;
    ctrl_t            ctl;
    logic [LANES-1:0] lane_bad;
    logic             unused_bits;

    assign unused_bits = ^{ctl_wdata[VAL_BIT-1:0], ctrl_q[NCTL-1:USED_CTL]};

    sysctl_ctrl_bank #(.NCTL(NCTL)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .we     (ctl_we),
        .sel    (ctl_sel),
        .val    (ctl_wdata[VAL_BIT]),
        .ctrl_q (ctrl_q)
    );

    assign ctl = ctrl_t'(ctrl_q[USED_CTL-1:0]);

    sysctl_par_gen #(.LANES(LANES)) u_gen (
        .clk       (clk),
        .rst       (rst),
        .we        (mem_we),
        .be        (mem_be),
        .wdata     (mem_wdata),
        .force_bad (ctl.force_bad),
        .par       (par_out),
        .par_we    (par_we)
    );

    sysctl_par_check #(.LANES(LANES)) u_chk (
        .rd       (mem_rd),
        .be       (mem_be),
        .rdata    (mem_rdata),
        .rpar     (mem_rpar),
        .lane_bad (lane_bad)
    );

    sysctl_err_track u_err (
        .clk    (clk),
        .rst    (rst),
        .hit    (|lane_bad),
        .rep_en (ctl.rep_en),
        .clr    (err_clr),
        .flag   (err_flag)
    );

    assign par_irq     = err_flag && ctl.rep_en;
    assign sys_err_req = par_irq && ctl.syserr_en;

    always_comb begin
        status_word              = '0;
        status_word[STAT_PE_BIT] = ctl.rep_en;
    end

    assign rom_low_en   = ~ctl.rom_hide;
    assign line1_disc   = ctl.line1_off;
    assign line2_disc   = ctl.line2_off;
    assign dialer_line2 = ctl.dial_line2;

    assert_nmi_masked_R7: assert property (@(posedge clk) disable iff (rst)
        !ctl.syserr_en |-> !sys_err_req);

    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (rst)
        par_irq |-> err_flag);

    assert_spare_write_R10: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && ctl_sel == SEL_W'(NCTL-1)) |=>
            $stable({rom_low_en, line1_disc, line2_disc, dialer_line2, status_word}));

    assert_reset_outputs_R2: assert property (@(posedge clk)
        rst |=> rom_low_en && !line1_disc && !line2_disc && !dialer_line2 && !err_flag);

endmodule

// File: tb/sysctl_parity_unit_bench.sv
`timescale 1ns/1ps
module sysctl_parity_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [2:0]  ctl_sel = '0;
    logic [15:0] ctl_wdata = '0;
    logic        mem_we = 1'b0, mem_rd = 1'b0;
    logic [1:0]  mem_be = '0;
    logic [15:0] mem_wdata = '0, mem_rdata = '0;
    logic [1:0]  mem_rpar = '0;
    logic        err_clr = 1'b0;
    logic [1:0]  par_out, par_we;
    logic        err_flag, par_irq, sys_err_req;
    logic [15:0] status_word;
    logic        rom_low_en, line1_disc, line2_disc, dialer_line2;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_ctrl = '0;

    always #10 clk = ~clk;

    sysctl_parity_unit u_sysctl_parity_unit (
        .clk, .rst, .ctl_we, .ctl_sel, .ctl_wdata, .mem_we, .mem_rd, .mem_be,
        .mem_wdata, .mem_rdata, .mem_rpar, .err_clr, .par_out, .par_we,
        .err_flag, .par_irq, .sys_err_req, .status_word, .rom_low_en,
        .line1_disc, .line2_disc, .dialer_line2
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic gp(input logic [7:0] b);
        return ($countones(b) % 2) == 0;
    endfunction

    task automatic chk_ctl_outputs(input string tag);
        chk({tag, " R9 rom"},    16'(rom_low_en),   16'(!m_ctrl[3]));
        chk({tag, " R9 line1"},  16'(line1_disc),   16'(m_ctrl[4]));
        chk({tag, " R9 line2"},  16'(line2_disc),   16'(m_ctrl[5]));
        chk({tag, " R9 dialer"}, 16'(dialer_line2), 16'(m_ctrl[6]));
        chk({tag, " R8 status"}, status_word,       16'(m_ctrl[1]) << 10);
    endtask

    task automatic wr_ctl(input logic [2:0] sel, input logic v, input logic [14:0] junk);
        @(negedge clk);
        ctl_we = 1'b1; ctl_sel = sel; ctl_wdata = {v, junk};
        @(negedge clk);
        ctl_we = 1'b0; ctl_wdata = '0;
        if (sel != 3'd7) m_ctrl[sel] = v;
    endtask

    task automatic rd_mem(input logic [15:0] d, input logic [1:0] p, input logic [1:0] be);
        @(negedge clk);
        mem_rd = 1'b1; mem_rdata = d; mem_rpar = p; mem_be = be;
        @(negedge clk);
        mem_rd = 1'b0; mem_be = '0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] d;
        logic [1:0]  good;
        logic        exp_err;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        chk_ctl_outputs("R2");
        chk("R2 flag", 16'(err_flag), 16'd0);
        chk("R2 irq",  16'(par_irq),  16'd0);
        chk("R2 nmi",  16'(sys_err_req), 16'd0);

        // R1, R9, R8: every control set then cleared, junk in low data bits
        for (int k = 0; k < 7; k++) begin
            wr_ctl(3'(k), 1'b1, 15'h0000);
            chk_ctl_outputs("R1 set");
            wr_ctl(3'(k), 1'b0, 15'h7FFF);
            chk_ctl_outputs("R1 clr");
        end
        // R1: several controls held together
        wr_ctl(3'd4, 1'b1, 15'h1234);
        wr_ctl(3'd6, 1'b1, 15'h4321);
        wr_ctl(3'd3, 1'b1, 15'h0F0F);
        chk_ctl_outputs("R1 multi");
        // R10: spare control write
        wr_ctl(3'd7, 1'b1, 15'h7FFF);
        chk_ctl_outputs("R10 spare");
        chk("R10 par", 16'(par_out), {14'd0, gp(mem_wdata[15:8]), gp(mem_wdata[7:0])});
        wr_ctl(3'd4, 1'b0, 15'h0);
        wr_ctl(3'd6, 1'b0, 15'h0);
        wr_ctl(3'd3, 1'b0, 15'h0);

        // R3: full sweep of byte values on both lanes
        @(negedge clk);
        mem_we = 1'b1; mem_be = 2'b11;
        for (int v = 0; v < 256; v++) begin
            mem_wdata = {8'(v), 8'(v) ^ 8'hA5};
            #1;
            chk("R3 parity", 16'(par_out), {14'd0, gp(mem_wdata[15:8]), gp(mem_wdata[7:0])});
        end
        // R3 write enables
        for (int b = 0; b < 4; b++) begin
            mem_be = 2'(b); mem_we = 1'b1; #1;
            chk("R3 par_we on", 16'(par_we), 16'(b));
            mem_we = 1'b0; #1;
            chk("R3 par_we off", 16'(par_we), 16'd0);
        end

        // R4: forced bad parity
        wr_ctl(3'd2, 1'b1, 15'h0);
        mem_we = 1'b1; mem_be = 2'b11;
        for (int v = 0; v < 256; v += 17) begin
            mem_wdata = {8'(v) ^ 8'h3C, 8'(v)};
            #1;
            chk("R4 forced", 16'(par_out), {14'd0, !gp(mem_wdata[15:8]), !gp(mem_wdata[7:0])});
        end
        mem_we = 1'b0;
        wr_ctl(3'd2, 1'b0, 15'h0);

        // R5, R7: sweep enables, strobes and corrupted lanes
        for (int pe = 0; pe < 2; pe++) begin
            for (int se = 0; se < 2; se++) begin
                wr_ctl(3'd1, 1'(pe), 15'h0);
                wr_ctl(3'd0, 1'(se), 15'h0);
                for (int be = 0; be < 4; be++) begin
                    for (int cm = 0; cm < 4; cm++) begin
                        d = 16'(16'h1357 * (be * 4 + cm + 1));
                        good = {gp(d[15:8]), gp(d[7:0])};
                        rd_mem(d, good ^ 2'(cm), 2'(be));
                        exp_err = (pe == 1) && ((be & cm) != 0);
                        chk("R5 flag", 16'(err_flag), 16'(exp_err));
                        chk("R7 irq",  16'(par_irq),  16'(exp_err));
                        chk("R7 nmi",  16'(sys_err_req), 16'(exp_err && se == 1));
                        clear_flag();
                        chk("R6 cleared", 16'(err_flag), 16'd0);
                    end
                end
            end
        end

        // R6: sticky across clean reads, set wins over simultaneous clear
        rd_mem(16'h00FF, 2'b00, 2'b01);
        rd_mem(16'h0000, 2'b11, 2'b11);
        rd_mem(16'h0000, 2'b11, 2'b11);
        chk("R6 sticky", 16'(err_flag), 16'd1);
        @(negedge clk);
        err_clr = 1'b1; mem_rd = 1'b1; mem_rdata = 16'h0100; mem_rpar = 2'b11; mem_be = 2'b10;
        @(negedge clk);
        err_clr = 1'b0; mem_rd = 1'b0; mem_be = '0;
        chk("R6 set wins", 16'(err_flag), 16'd1);
        // R7: dropping reporting enable masks both requests
        wr_ctl(3'd1, 1'b0, 15'h0);
        chk("R7 irq masked", 16'(par_irq), 16'd0);
        chk("R7 nmi masked", 16'(sys_err_req), 16'd0);
        chk("R8 status off", status_word, 16'd0);
        clear_flag();
        chk("R6 final clear", 16'(err_flag), 16'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule